// File: doc/BRIEF.md
# Reconfigurable Interleaved Multiphase PWM Generator

This block produces the gate pulses for an interleaved buck stage made of several cells. Each cell holds two controllable switches fed from one duty command. Every cell gets one unsigned fixed-point duty value and one fault bit. From these the block drives two gate outputs per cell. The second gate of a cell repeats the first gate's pulse half a switching period later. The carriers of the healthy cells are spread evenly over the period in ascending cell-index order. When the fault mask changes, the spread is worked out again over the remaining healthy cells, so interleaving carries on after a cell is lost.

A free-running carrier counter divides each switching period into `PERIOD` clock ticks. With the defaults this is 2000 ticks at 100 MHz, which gives 50 kHz. Duty commands, the fault mask and the derived phase offsets are all captured together on the last tick of a carrier period. A controller can therefore update its commands at any point in the period. The pulses change only from the next period onward.

Top module: `interleave_pwm`

## Requirements
- R1: While reset is held, and on the first cycle after it, every gate output is low. Until the first carrier wrap, every cell is treated as disabled, so all gates stay low.
- R2: The carrier counts 0 to PERIOD-1 and then returns to 0. Duty commands and the fault mask are sampled only on the clock edge where the count leaves PERIOD-1.
- R3: The duty command of cell i sits in bits [i*DUTY_W +: DUTY_W] of `duty_cmd` as an unsigned fraction of 2^DUTY_W. Its on-time is ton = floor(duty*PERIOD/2^DUTY_W) ticks. With cell offset off, gate A of a healthy cell is high exactly when the carrier count c seen one clock earlier satisfies (c - off) mod PERIOD < ton.
- R4: With M healthy cells, the healthy cell of rank r gets offset floor(r*PERIOD/M). Rank r is the number of healthy cells with a lower index.
- R5: A cell whose `fault_mask` bit is 1 holds both of its gate outputs low for the whole period in which the mask is active.
- R6: Gate B of a cell uses the same on-time, shifted by PERIOD/2 ticks: it is high when ((c - off - PERIOD/2) mod PERIOD) < ton. Gate A and gate B of a cell are never high at the same time.
- R7: A duty command at or above one half (MSB set) is treated as 2^(DUTY_W-1)-1. This makes on-time always shorter than PERIOD/2.
- R8: A change to a duty command or to the fault mask during a carrier period has no effect on any gate until the period that follows the next wrap.
- R9: When every cell is marked faulty, all gate outputs stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Carrier clock |
| rst | input | 1 | Synchronous active-high reset |
| duty_cmd | input | NCELL*DUTY_W | Per-cell duty commands, unsigned fraction, cell i in slice i |
| fault_mask | input | NCELL | 1 marks a cell as faulty |
| gate_a | output | NCELL | First switch gate of each cell |
| gate_b | output | NCELL | Second switch gate of each cell, half a period later |

## Verification
The hardest case to reach is a command or mask change that lands in the middle of a period. The bench has to show that nothing moves until the wrap, and then that every healthy cell moves to its new rank-based offset on the same tick. The stimulus tracks the carrier position in its reference model. It applies duty changes, and masks that remove first a non-zero-index cell and then cell 0, exactly half-way through a period. The reference then predicts every gate on every clock across the boundary. Clamped commands are checked by summing gate high-time over one full period.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  parameter int unsigned PWM_CELLS_DEF  = 4;
  parameter int unsigned PWM_DUTY_W_DEF = 16;
  parameter int unsigned PWM_PERIOD_DEF = 2000;
endpackage

// File: rtl/pwm_carrier.sv
module pwm_carrier #(
  parameter int unsigned PERIOD = pwm_pkg::PWM_PERIOD_DEF,
  localparam int unsigned CNT_W = $clog2(PERIOD)
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  assign wrap = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (wrap) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

  assert_cnt_range_R2: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);
  assert_cnt_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    (cnt == LAST) |=> (cnt == '0));
endmodule

// File: rtl/pwm_phase_plan.sv
module pwm_phase_plan #(
  parameter int unsigned NCELL  = pwm_pkg::PWM_CELLS_DEF,
  parameter int unsigned DUTY_W = pwm_pkg::PWM_DUTY_W_DEF,
  parameter int unsigned PERIOD = pwm_pkg::PWM_PERIOD_DEF,
  localparam int unsigned CNT_W = $clog2(PERIOD)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         load,
  input  logic [NCELL*DUTY_W-1:0]      duty_cmd,
  input  logic [NCELL-1:0]             fault_mask,
  output logic [NCELL-1:0][CNT_W-1:0]  ton_q,
  output logic [NCELL-1:0][CNT_W-1:0]  off_q,
  output logic [NCELL-1:0]             healthy_q
);
  localparam int unsigned PW = DUTY_W + CNT_W;
  localparam logic [DUTY_W-1:0] DMAX = {1'b0, {(DUTY_W-1){1'b1}}};
  localparam int unsigned HALF = PERIOD / 2;

  logic [NCELL-1:0][CNT_W-1:0] ton_n, off_n;

  always_comb begin
    int m, r;
    logic [DUTY_W-1:0] d;
    logic [PW-1:0] prod;
    m = 0;
    for (int i = 0; i < NCELL; i++) if (!fault_mask[i]) m++;
    r = 0;
    for (int i = 0; i < NCELL; i++) begin
      d = duty_cmd[i*DUTY_W +: DUTY_W];
      if (d[DUTY_W-1]) d = DMAX;
      prod = PW'(d) * PW'(PERIOD);
      ton_n[i] = prod[DUTY_W +: CNT_W];
      off_n[i] = '0;
      if (!fault_mask[i]) begin
        off_n[i] = CNT_W'((PERIOD * r) / m);
        r++;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ton_q     <= '0;
      off_q     <= '0;
      healthy_q <= '0;
    end else if (load) begin
      ton_q     <= ton_n;
      off_q     <= off_n;
      healthy_q <= ~fault_mask;
    end
  end

  assert_hold_midperiod_R8: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($stable(ton_q) && $stable(off_q) && $stable(healthy_q)));

  for (genvar g = 0; g < NCELL; g++) begin : g_chk
    assert_ton_clamped_R7: assert property (@(posedge clk) disable iff (rst)
      ton_q[g] < CNT_W'(HALF));
  end
endmodule

// File: rtl/pwm_cell_gate.sv
module pwm_cell_gate #(
  parameter int unsigned PERIOD = pwm_pkg::PWM_PERIOD_DEF,
  localparam int unsigned CNT_W = $clog2(PERIOD)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] ton,
  input  logic [CNT_W-1:0] off,
  input  logic             healthy,
  output logic             gate_a,
  output logic             gate_b
);
  localparam logic [CNT_W:0] P_X = (CNT_W+1)'(PERIOD);
  localparam logic [CNT_W:0] H_X = (CNT_W+1)'(PERIOD / 2);

  logic [CNT_W:0] pa, pb;

  always_comb begin
    if (cnt >= off) pa = {1'b0, cnt} - {1'b0, off};
    else            pa = {1'b0, cnt} + P_X - {1'b0, off};
    if (pa >= H_X)  pb = pa - H_X;
    else            pb = pa + P_X - H_X;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_a <= 1'b0;
      gate_b <= 1'b0;
    end else begin
      gate_a <= healthy && (pa < {1'b0, ton});
      gate_b <= healthy && (pb < {1'b0, ton});
    end
  end

  assert_no_overlap_R6: assert property (@(posedge clk) disable iff (rst)
    !(gate_a && gate_b));
  assert_faulty_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    !healthy |=> (!gate_a && !gate_b));
endmodule

// File: rtl/interleave_pwm.sv
module interleave_pwm #(
  parameter int unsigned NCELL  = pwm_pkg::PWM_CELLS_DEF,
  parameter int unsigned DUTY_W = pwm_pkg::PWM_DUTY_W_DEF,
  parameter int unsigned PERIOD = pwm_pkg::PWM_PERIOD_DEF
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NCELL*DUTY_W-1:0] duty_cmd,
  input  logic [NCELL-1:0]        fault_mask,
  output logic [NCELL-1:0]        gate_a,
  output logic [NCELL-1:0]        gate_b
);
  localparam int unsigned CNT_W = $clog2(PERIOD);

  logic [CNT_W-1:0]            cnt;
  logic                        wrap;
  logic [NCELL-1:0][CNT_W-1:0] ton_q, off_q;
  logic [NCELL-1:0]            healthy_q;

  pwm_carrier #(.PERIOD(PERIOD)) u_carrier (
    .clk(clk), .rst(rst), .cnt(cnt), .wrap(wrap)
  );

  pwm_phase_plan #(.NCELL(NCELL), .DUTY_W(DUTY_W), .PERIOD(PERIOD)) u_plan (
    .clk(clk), .rst(rst), .load(wrap), .duty_cmd(duty_cmd),
    .fault_mask(fault_mask), .ton_q(ton_q), .off_q(off_q),
    .healthy_q(healthy_q)
  );

  for (genvar g = 0; g < NCELL; g++) begin : g_cell
    pwm_cell_gate #(.PERIOD(PERIOD)) u_gate (
      .clk(clk), .rst(rst), .cnt(cnt), .ton(ton_q[g]), .off(off_q[g]),
      .healthy(healthy_q[g]), .gate_a(gate_a[g]), .gate_b(gate_b[g])
    );
  end

  assert_all_faulty_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    (healthy_q == '0) |=> (gate_a == '0 && gate_b == '0));
endmodule

// File: tb/interleave_pwm_bench.sv
module interleave_pwm_bench;
  localparam int NC = 4;
  localparam int DW = 16;
  localparam int P  = 200;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NC*DW-1:0] duty_cmd = '0;
  logic [NC-1:0]    fault_mask = '0;
  logic [NC-1:0]    gate_a, gate_b;

  interleave_pwm #(.NCELL(NC), .DUTY_W(DW), .PERIOD(P)) u_interleave_pwm (
    .clk(clk), .rst(rst), .duty_cmd(duty_cmd), .fault_mask(fault_mask),
    .gate_a(gate_a), .gate_b(gate_b)
  );

  always #10 clk = ~clk;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;
  string cur_req = "R1";

  // behavioural reference model
  int mcnt;
  int mton [NC];
  int moff [NC];
  bit mh   [NC];
  bit ea   [NC];
  bit eb   [NC];

  always @(posedge clk) begin
    if (rst) begin
      mcnt = 0;
      foreach (mh[i]) begin mh[i] = 0; mton[i] = 0; moff[i] = 0; ea[i] = 0; eb[i] = 0; end
    end else begin
      for (int i = 0; i < NC; i++) begin
        int pa, pb;
        pa = (mcnt - moff[i] + P) % P;
        pb = (pa - P/2 + P) % P;
        ea[i] = mh[i] && (pa < mton[i]);
        eb[i] = mh[i] && (pb < mton[i]);
      end
      if (mcnt == P-1) begin
        int m, r;
        m = 0; r = 0;
        for (int i = 0; i < NC; i++) if (!fault_mask[i]) m++;
        for (int i = 0; i < NC; i++) begin
          longint d;
          d = duty_cmd[i*DW +: DW];
          if (d >= 32768) d = 32767;
          mton[i] = int'((d * P) / 65536);
          mh[i] = !fault_mask[i];
          moff[i] = 0;
          if (mh[i]) begin moff[i] = (r * P) / m; r++; end
        end
        mcnt = 0;
      end else mcnt++;
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      for (int i = 0; i < NC; i++) begin
        vectors++;
        if (gate_a[i] !== ea[i] || gate_b[i] !== eb[i]) begin
          errors++;
          $display("FAIL %s cell %0d t=%0t: got a=%b b=%b expected a=%b b=%b",
                   cur_req, i, $time, gate_a[i], gate_b[i], ea[i], eb[i]);
        end
        vectors++;
        if (gate_a[i] && gate_b[i]) begin
          errors++;
          $display("FAIL R6 cell %0d overlap: got a=1 b=1 expected not both", i);
        end
      end
    end
  end

  task automatic set_duty(input int c, input int v);
    duty_cmd[c*DW +: DW] = DW'(v);
  endtask

  task automatic to_mid();
    @(negedge clk);
    while (mcnt != P/2) @(negedge clk);
  endtask

  task automatic periods(input int n);
    repeat (n * P) @(negedge clk);
  endtask

  task automatic check_high(input string req, input int c, input int exp_cnt);
    int s;
    s = 0;
    repeat (P) begin
      @(negedge clk);
      s += gate_a[c];
    end
    vectors++;
    if (s != exp_cnt) begin
      errors++;
      $display("FAIL %s cell %0d high ticks: got %0d expected %0d", req, c, s, exp_cnt);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  initial begin
    // R1: reset state
    repeat (4) @(negedge clk);
    vectors++;
    if (gate_a !== '0 || gate_b !== '0) begin
      errors++;
      $display("FAIL R1 in reset: got a=%b b=%b expected 0000 0000", gate_a, gate_b);
    end
    for (int i = 0; i < NC; i++) set_duty(i, 16384);
    rst = 1'b0;
    @(negedge clk);
    vectors++;
    if (gate_a !== '0 || gate_b !== '0) begin
      errors++;
      $display("FAIL R1 after reset: got a=%b b=%b expected 0000 0000", gate_a, gate_b);
    end
    cur_req = "R2";
    periods(2);
    // R3: distinct duties, all healthy
    cur_req = "R3";
    set_duty(0, 6554); set_duty(1, 13107); set_duty(2, 26214); set_duty(3, 1);
    periods(3);
    check_high("R3", 2, (26214 * P) / 65536);
    // R4: lose cell 1 mid-period, three-way spread
    cur_req = "R8";
    to_mid();
    fault_mask = 4'b0010;
    set_duty(0, 16384); set_duty(2, 16384); set_duty(3, 16384);
    @(negedge clk);
    cur_req = "R4";
    periods(3);
    // R5: lose master cell 0 as well
    cur_req = "R5";
    to_mid();
    fault_mask = 4'b0011;
    periods(3);
    check_high("R5", 0, 0);
    // R7: clamped commands
    cur_req = "R7";
    fault_mask = 4'b0000;
    set_duty(0, 65535); set_duty(1, 32768); set_duty(2, 32767); set_duty(3, 40000);
    periods(3);
    check_high("R7", 0, (32767 * P) / 65536);
    check_high("R7", 1, (32767 * P) / 65536);
    // R8: duty change mid-period
    cur_req = "R8";
    to_mid();
    set_duty(0, 8192); set_duty(1, 0);
    periods(3);
    check_high("R8", 1, 0);
    // R9: all faulty
    cur_req = "R9";
    fault_mask = 4'b1111;
    periods(3);
    check_high("R9", 3, 0);
    // R4: single healthy cell, then recovery to two
    cur_req = "R4";
    fault_mask = 4'b0111;
    set_duty(3, 20000);
    periods(3);
    fault_mask = 4'b0101;
    set_duty(1, 20000);
    periods(3);
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end
endmodule